// File: doc/BRIEF.md
# Dual-Issue Instruction Pairing Checker

This block sits at the head of an instruction queue and looks at the two oldest decoded instructions every cycle. The older one (slot 0) is sent to the primary pipe unless it must wait. The younger one (slot 1) is sent to the secondary pipe in the same cycle only when the two are independent in a strict sense: both are simple single-cycle operations, neither has an immediate operand or an embedded address, and they touch no register in common. Sharing any register blocks pairing, whether it is written or only read.

When slot 0 uses a register for address generation and the instruction issued just before it writes that register, the block holds slot 0 for one interlock cycle and issues nothing. The queue is told how many entries were taken (0, 1 or 2), so an instruction that did not pair stays at the head and becomes slot 0 in the next cycle. A registered pulse marks each cycle in which the secondary pipe was loaded, so an outside counter can measure how often pairing happens.

Top module: `dual_issue_pair_check`

## Requirements
- R1: When slot 0 is not valid, neither pipe is issued, `take_cnt` is 0 and `agi_stall` is 0.
- R2: When slot 0 is valid and has no address hazard, `go_pri` is 1. If slot 1 is not valid, `go_sec` is 0 and `take_cnt` is 1.
- R3: `go_sec` is 1 only if both `sN_simple` inputs are 1. Here 1 means a simple single-cycle instruction.
- R4: `go_sec` is 0 whenever `s0_imm` or `s1_imm` is 1. Either slot blocks pairing with an immediate operand or an embedded address.
- R5: `go_sec` is 0 whenever the OR of `dst`, `src` and `agu` of slot 0 shares any bit with the same OR for slot 1. Bit i of each 8-bit mask stands for general register i.
- R6: When slot 0 issues and R3, R4 and R5 all allow it with slot 1 valid, `go_sec` is 1 and `take_cnt` is 2. Otherwise `take_cnt` equals `go_pri`.
- R7: Slot 0 has an address hazard when it is valid and its `agu` mask shares a bit with the destination mask of the last instruction issued in the previous cycle. That instruction is slot 1's if a pair issued, otherwise slot 0's. On a hazard, `agi_stall` is 1, `go_pri` and `go_sec` are 0, and `take_cnt` is 0.
- R8: A cycle that issues nothing leaves no destination behind, so the same slot 0 issues in the following cycle. An interlock never lasts two cycles in a row.
- R9: `pair_evt` is 1 in the cycle that follows each cycle with `go_sec` = 1, and 0 after every other cycle.
- R10: After reset `pair_evt` is 0 and no prior destination is remembered, so the first instruction issues without an interlock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s0_vld | input | 1 | Slot 0 holds an instruction |
| s0_simple | input | 1 | Slot 0 is a simple single-cycle instruction |
| s0_imm | input | 1 | Slot 0 carries an immediate operand or an embedded address |
| s0_dst | input | 8 | Slot 0 written-register mask |
| s0_src | input | 8 | Slot 0 read-register mask |
| s0_agu | input | 8 | Slot 0 address-generation register mask |
| s1_vld | input | 1 | Slot 1 holds an instruction |
| s1_simple | input | 1 | Slot 1 is a simple single-cycle instruction |
| s1_imm | input | 1 | Slot 1 carries an immediate operand or an embedded address |
| s1_dst | input | 8 | Slot 1 written-register mask |
| s1_src | input | 8 | Slot 1 read-register mask |
| s1_agu | input | 8 | Slot 1 address-generation register mask |
| go_pri | output | 1 | Slot 0 issues to the primary pipe |
| go_sec | output | 1 | Slot 1 issues to the secondary pipe |
| take_cnt | output | 2 | Entries the queue must pop this cycle |
| agi_stall | output | 1 | Address-generation interlock cycle |
| pair_evt | output | 1 | Registered pulse: secondary pipe was loaded last cycle |

## Verification
`go_pri`, `go_sec`, `take_cnt` and `agi_stall` are combinational in the current slots and the remembered destination. The bench therefore drives the slots just after a falling edge and samples these outputs one time unit later, before the next rising edge. The remembered destination and `pair_evt` change only at a rising edge. The bench's model updates its own copy of the destination after each check, and it compares `pair_evt` in the next driven cycle with the pairing result the model predicted one cycle earlier. Random streams with sparse register masks exercise every pairing rule. Directed back-to-back sequences force split pairs followed by interlocks and interlocks followed by recovery.

// File: rtl/dual_pair_pkg.sv
package dual_pair_pkg;
  localparam int unsigned GPR_N   = 8;
  localparam int unsigned WAYS    = 2;
  localparam int unsigned TAKE_W  = $clog2(WAYS + 1);

  typedef logic [GPR_N-1:0] gpr_mask_t;

  typedef struct packed {
    logic      vld;
    logic      simple;
    logic      imm;
    gpr_mask_t dst;
    gpr_mask_t src;
    gpr_mask_t agu;
  } slot_t;
endpackage

// File: rtl/pair_rules.sv
module pair_rules
  import dual_pair_pkg::*;
(
  input  slot_t older,
  input  slot_t younger,
  output logic  can_pair
);
  gpr_mask_t touch_old;
  gpr_mask_t touch_yng;
  logic      both_simple;
  logic      no_imm;
  logic      disjoint;

  always_comb begin
    touch_old   = older.dst | older.src | older.agu;
    touch_yng   = younger.dst | younger.src | younger.agu;
    both_simple = older.simple & younger.simple;
    no_imm      = ~older.imm & ~younger.imm;
    disjoint    = ~|(touch_old & touch_yng);
    can_pair    = younger.vld & both_simple & no_imm & disjoint;
  end
endmodule

// File: rtl/agi_tracker.sv
module agi_tracker
  import dual_pair_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      issued_any,
  input  gpr_mask_t tail_dst,
  input  gpr_mask_t head_agu,
  input  logic      head_vld,
  output logic      hazard
);
  gpr_mask_t last_dst_q;
  gpr_mask_t last_dst_d;

  always_comb begin
    last_dst_d = issued_any ? tail_dst : '0;
    hazard     = head_vld & |(head_agu & last_dst_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_dst_q <= '0;
    else        last_dst_q <= last_dst_d;
  end
endmodule

// File: rtl/dual_issue_pair_check.sv
module dual_issue_pair_check
  import dual_pair_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s0_vld,
  input  logic              s0_simple,
  input  logic              s0_imm,
  input  logic [GPR_N-1:0]  s0_dst,
  input  logic [GPR_N-1:0]  s0_src,
  input  logic [GPR_N-1:0]  s0_agu,
  input  logic              s1_vld,
  input  logic              s1_simple,
  input  logic              s1_imm,
  input  logic [GPR_N-1:0]  s1_dst,
  input  logic [GPR_N-1:0]  s1_src,
  input  logic [GPR_N-1:0]  s1_agu,
  output logic              go_pri,
  output logic              go_sec,
  output logic [TAKE_W-1:0] take_cnt,
  output logic              agi_stall,
  output logic              pair_evt
);
  slot_t     slot_a;
  slot_t     slot_b;
  logic      can_pair;
  logic      hazard;
  gpr_mask_t tail_dst;
  logic      pair_evt_d;

  always_comb begin
    slot_a = '{vld: s0_vld, simple: s0_simple, imm: s0_imm,
               dst: s0_dst, src: s0_src, agu: s0_agu};
    slot_b = '{vld: s1_vld, simple: s1_simple, imm: s1_imm,
               dst: s1_dst, src: s1_src, agu: s1_agu};
  end

  pair_rules u_rules (
    .older    (slot_a),
    .younger  (slot_b),
    .can_pair (can_pair)
  );

  agi_tracker u_agi (
    .clk        (clk),
    .rst_n      (rst_n),
    .issued_any (go_pri),
    .tail_dst   (tail_dst),
    .head_agu   (s0_agu),
    .head_vld   (s0_vld),
    .hazard     (hazard)
  );

  always_comb begin
    agi_stall  = hazard;
    go_pri     = s0_vld & ~hazard;
    go_sec     = go_pri & can_pair;
    take_cnt   = TAKE_W'(go_pri) + TAKE_W'(go_sec);
    tail_dst   = go_sec ? s1_dst : s0_dst;
    pair_evt_d = go_sec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pair_evt <= 1'b0;
    else        pair_evt <= pair_evt_d;
  end
endmodule

// File: rtl/dual_issue_pair_check_chk.sv
module dual_issue_pair_check_chk
  import dual_pair_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              s0_vld,
  input logic              s0_simple,
  input logic              s0_imm,
  input logic [GPR_N-1:0]  s0_dst,
  input logic [GPR_N-1:0]  s0_src,
  input logic [GPR_N-1:0]  s0_agu,
  input logic              s1_vld,
  input logic              s1_simple,
  input logic              s1_imm,
  input logic [GPR_N-1:0]  s1_dst,
  input logic [GPR_N-1:0]  s1_src,
  input logic [GPR_N-1:0]  s1_agu,
  input logic              go_pri,
  input logic              go_sec,
  input logic [TAKE_W-1:0] take_cnt,
  input logic              agi_stall,
  input logic              pair_evt
);
  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  // R1
  idle_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !s0_vld |-> (!go_pri && !go_sec && take_cnt == '0 && !agi_stall));

  // R3
  sec_simple_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go_sec |-> (s0_simple && s1_simple));

  // R4
  sec_no_imm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go_sec |-> (!s0_imm && !s1_imm));

  // R5
  sec_disjoint_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go_sec |-> (((s0_dst | s0_src | s0_agu) & (s1_dst | s1_src | s1_agu)) == '0));

  // R6
  pair_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go_sec |-> (go_pri && take_cnt == TAKE_W'(2)));

  // R7
  stall_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    agi_stall |-> (!go_pri && !go_sec && take_cnt == '0));

  // R8
  no_double_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    agi_stall |=> !agi_stall);

  // R9
  pair_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (pair_evt == $past(go_sec)));
endmodule

bind dual_issue_pair_check dual_issue_pair_check_chk i_chk (.*);

// File: tb/test_dual_issue_pair_check.sv
module test_dual_issue_pair_check;
  import dual_pair_pkg::*;

  logic clk = 1'b0;
  logic rst_n;
  logic s0_vld, s0_simple, s0_imm, s1_vld, s1_simple, s1_imm;
  logic [7:0] s0_dst, s0_src, s0_agu, s1_dst, s1_src, s1_agu;
  logic go_pri, go_sec, agi_stall, pair_evt;
  logic [1:0] take_cnt;

  int checks = 0;
  int fails  = 0;
  logic [7:0] m_last = '0;
  logic       m_prev_sec = 1'b0;
  logic       done = 1'b0;

  always #2.5 clk = ~clk;

  dual_issue_pair_check i_dual_issue_pair_check (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic f_hazard(input logic v0, input logic [7:0] agu0,
                                    input logic [7:0] last);
    return v0 && ((agu0 & last) != 0);
  endfunction

  function automatic logic f_pairable();
    return s1_vld && s0_simple && s1_simple && !s0_imm && !s1_imm &&
           (((s0_dst | s0_src | s0_agu) & (s1_dst | s1_src | s1_agu)) == 0);
  endfunction

  task automatic drive(input logic v0, input logic sm0, input logic im0,
                       input logic [7:0] d0, input logic [7:0] r0, input logic [7:0] a0,
                       input logic v1, input logic sm1, input logic im1,
                       input logic [7:0] d1, input logic [7:0] r1, input logic [7:0] a1);
    s0_vld = v0; s0_simple = sm0; s0_imm = im0; s0_dst = d0; s0_src = r0; s0_agu = a0;
    s1_vld = v1; s1_simple = sm1; s1_imm = im1; s1_dst = d1; s1_src = r1; s1_agu = a1;
  endtask

  // one cycle: drive after falling edge, check before rising edge, advance model
  task automatic step(input string tag);
    logic hz, ep, es;
    #1;
    hz = f_hazard(s0_vld, s0_agu, m_last);
    ep = s0_vld && !hz;
    es = ep && f_pairable();
    chk({tag, " R7 agi_stall"}, agi_stall, hz);
    chk({tag, " R2 go_pri"},    go_pri,    ep);
    chk({tag, " R6 go_sec"},    go_sec,    es);
    chk({tag, " R6 take_cnt"},  take_cnt,  int'(ep) + int'(es));
    chk({tag, " R9 pair_evt"},  pair_evt,  m_prev_sec);
    m_prev_sec = es;
    m_last = ep ? (es ? s1_dst : s0_dst) : 8'h00;
    @(negedge clk);
  endtask

  function automatic logic [7:0] sparse();
    int k = $urandom_range(0, 3);
    return (k == 0) ? 8'h00 : (8'h01 << $urandom_range(0, 7));
  endfunction

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    drive(0,0,0,0,0,0, 0,0,0,0,0,0);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10: nothing remembered after reset; agu on every register still issues
    chk("R10 pair_evt after reset", pair_evt, 0);
    drive(1,1,0,8'h00,8'h00,8'hFF, 0,0,0,0,0,0);
    step("R10 first issue");

    // R1: empty head
    drive(0,1,0,8'h01,0,0, 1,1,0,8'h02,0,0);
    step("R1 empty head");
    // R2: lone instruction
    drive(1,1,0,8'h01,8'h02,0, 0,1,0,8'h04,0,0);
    step("R2 lone");
    // R6: clean pair
    drive(1,1,0,8'h01,8'h02,0, 1,1,0,8'h04,8'h08,0);
    step("R6 pair");
    // R3: complex in slot 1
    drive(1,1,0,8'h10,0,0, 1,0,0,8'h20,0,0);
    step("R3 complex");
    // R4: immediate in slot 0, then in slot 1
    drive(1,1,1,8'h10,0,0, 1,1,0,8'h20,0,0);
    step("R4 imm0");
    drive(1,1,0,8'h10,0,0, 1,1,1,8'h20,0,0);
    step("R4 imm1");
    // R5: read-read sharing only
    drive(1,1,0,8'h01,8'h40,0, 1,1,0,8'h02,8'h40,0);
    step("R5 shared read");
    // R7: split pair, then younger uses older's dst for address -> stall, R8 recover
    drive(1,1,0,8'h04,0,0, 1,1,0,8'h08,0,8'h04);
    step("R7 split");
    drive(1,1,0,8'h08,0,8'h04, 1,1,0,8'h80,0,0);
    step("R7 stall");
    step("R8 recover");
    // R7: pair issued, next head addresses slot 1's destination
    drive(1,1,0,8'h01,0,0, 1,1,0,8'h02,0,0);
    step("R7 pair tail");
    drive(1,1,0,8'h00,0,8'h02, 0,0,0,0,0,0);
    step("R7 tail hazard");
    step("R8 after tail stall");
    // R7: older slot of a pair does not count as the one just ahead
    drive(1,1,0,8'h01,0,0, 1,1,0,8'h02,0,0);
    step("R7 pair head");
    drive(1,1,0,8'h00,0,8'h01, 0,0,0,0,0,0);
    step("R7 head not ahead");

    for (int i = 0; i < 4000; i++) begin
      drive($urandom_range(0, 7) != 0, $urandom_range(0, 3) != 0, $urandom_range(0, 5) == 0,
            sparse(), sparse(), sparse(),
            $urandom_range(0, 5) != 0, $urandom_range(0, 3) != 0, $urandom_range(0, 5) == 0,
            sparse(), sparse(), sparse());
      step("rand R3 R4 R5 R6 R7 R9");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule